// File: doc/BRIEF.md
# Scan Test Port with Configuration Register Access

This block is a serial test access port of the 1149.1 kind. It is built around the sixteen-state controller, which is steered by TMS on each rising edge of TCK. A 4-bit instruction register picks the data path that sits between TDI and TDO. The available paths are a one-stage bypass stage, a read-only 32-bit identification word, an external boundary chain, and a 32-bit volatile configuration bank that can be written and read over the scan path.

Two further instructions raise a one-cycle request toward an external non-volatile store: one to save the bank and one to restore it. Three mode flags are driven straight from the current instruction: drive-from-boundary, clamp and high-impedance. The boundary cells live outside the block. They receive capture, shift and update enables, and they return their serial output on `bsr_so`.

All pins are plain control or serial pins, so the port has no valid/ready handshake and no back-pressure. Each TCK edge moves exactly one bit.

Top module: `cfg_tap_top`

## Requirements
- R1: While `trst_n` is low, the controller is in Test-Logic-Reset, the current instruction is the identification code 0010, `cfg_bank` equals `CFG_RESET` (default 0), and `tdo_oe`, the strobes and the mode flags are all low.
- R2: Five consecutive rising TCK edges with TMS high put the controller in Test-Logic-Reset from any state, and the current instruction becomes 0010.
- R3: In Capture-IR the instruction shift stage loads 0001. It shifts right from TDI during Shift-IR, so bit 0 leaves first. The current instruction changes only in Update-IR, so a partly or fully shifted code has no effect while the controller waits in Pause-IR.
- R4: The instruction codes decode as follows. 0000 is drive-from-boundary (boundary path). 0001 is sample (boundary path). 0010 is identification. 0100 writes the configuration bank. 0101 reads the bank. 0110 saves. 0111 restores. 1000 is clamp. 1001 is high-Z. Code 0011, codes 1010 through 1111, and save, restore, clamp and high-Z all use the bypass path.
- R5: The bypass stage loads 0 in Capture-DR and then passes TDI to TDO with one stage of delay.
- R6: The identification word is {version[3:0], part[15:0], manufacturer[10:0], 1'b1}, with default part 0x03A6 and manufacturer 0x033, giving 0x003A6067. It is loaded in Capture-DR and shifted out bit 0 first.
- R7: Under the bank-write code, the 32 bits shifted in (bit 0 first) are copied to `cfg_bank` in Update-DR. Under every other code, shifting through the data path leaves `cfg_bank` unchanged.
- R8: Under the bank-read code, Capture-DR loads `cfg_bank` into the shift path, and the bank is shifted out bit 0 first.
- R9: `save_strobe` (save code current) or `restore_strobe` (restore code current) is high for exactly one TCK cycle, starting at the edge that enters Run-Test/Idle. It is low while the controller stays in Run-Test/Idle.
- R10: `ext_test` is high only under code 0000, `clamp_en` only under 1000, and `highz_en` only under 1001.
- R11: TDO and `tdo_oe` change only on the falling TCK edge. `tdo_oe` is high exactly while the controller is in Shift-IR or Shift-DR.
- R12: Under codes 0000 and 0001, `bsr_capture`, `bsr_shift` and `bsr_update` are high in Capture-DR, Shift-DR and Update-DR respectively, and TDO carries `bsr_so` during Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, meaningful when `tdo_oe` is high |
| tdo_oe | output | 1 | Output enable for TDO |
| bsr_so | input | 1 | Serial return from the external boundary chain |
| bsr_capture | output | 1 | Boundary chain capture enable |
| bsr_shift | output | 1 | Boundary chain shift enable |
| bsr_update | output | 1 | Boundary chain update enable |
| ext_test | output | 1 | Boundary cells drive the pins |
| clamp_en | output | 1 | Hold pins at boundary values |
| highz_en | output | 1 | Float all outputs |
| cfg_bank | output | 32 | Volatile configuration bank |
| save_strobe | output | 1 | One-cycle request to store the bank |
| restore_strobe | output | 1 | One-cycle request to reload the bank |

## Verification
The assertions check the following on every cycle: a run of five TMS-high edges always ends in reset; the current instruction holds outside Update-IR and reset; the bypass stage is zero after capture; the bank changes only in Update-DR under the write code; a strobe never lasts two cycles; the output enable tracks the shift states. Only the bench scenarios can show bit order and values: the identification word, the write-then-read round trip of the bank, the 0001 capture pattern, a pending instruction held in Pause-IR, and TDO holding across a rising edge.

// File: rtl/cfg_tap_pkg.sv
`timescale 1ns/1ps
package cfg_tap_pkg;

  localparam int IR_W = 4;
  localparam int DR_W = 32;

  typedef enum logic [3:0] {
    TS_EX2_DR = 4'h0, TS_EX1_DR = 4'h1, TS_SHF_DR = 4'h2, TS_PAU_DR = 4'h3,
    TS_SEL_IR = 4'h4, TS_UPD_DR = 4'h5, TS_CAP_DR = 4'h6, TS_SEL_DR = 4'h7,
    TS_EX2_IR = 4'h8, TS_EX1_IR = 4'h9, TS_SHF_IR = 4'hA, TS_PAU_IR = 4'hB,
    TS_RTI    = 4'hC, TS_UPD_IR = 4'hD, TS_CAP_IR = 4'hE, TS_TLR    = 4'hF
  } tap_state_e;

  typedef logic [IR_W-1:0] ir_code_t;

  localparam ir_code_t OP_DRIVE   = 4'h0;
  localparam ir_code_t OP_SAMPLE  = 4'h1;
  localparam ir_code_t OP_IDENT   = 4'h2;
  localparam ir_code_t OP_CFG_WR  = 4'h4;
  localparam ir_code_t OP_CFG_RD  = 4'h5;
  localparam ir_code_t OP_CFG_SV  = 4'h6;
  localparam ir_code_t OP_CFG_RS  = 4'h7;
  localparam ir_code_t OP_CLAMP   = 4'h8;
  localparam ir_code_t OP_FLOAT   = 4'h9;
  localparam ir_code_t IR_CAPTURE = 4'b0001;

  typedef enum logic [1:0] {
    PATH_BYP  = 2'd0,
    PATH_BSR  = 2'd1,
    PATH_WIDE = 2'd2
  } dr_path_e;

  typedef struct packed {
    dr_path_e path;
    logic     cap_id;
    logic     cap_bank;
    logic     wr_bank;
    logic     save_req;
    logic     restore_req;
    logic     clamp;
    logic     highz;
    logic     ext;
  } ir_dec_t;

  function automatic ir_dec_t decode_ir(input ir_code_t c);
    ir_dec_t d;
    d      = '0;
    d.path = PATH_BYP;
    case (c)
      OP_DRIVE:  begin d.path = PATH_BSR;  d.ext = 1'b1;      end
      OP_SAMPLE: begin d.path = PATH_BSR;                     end
      OP_IDENT:  begin d.path = PATH_WIDE; d.cap_id = 1'b1;   end
      OP_CFG_WR: begin d.path = PATH_WIDE; d.wr_bank = 1'b1;  end
      OP_CFG_RD: begin d.path = PATH_WIDE; d.cap_bank = 1'b1; end
      OP_CFG_SV: d.save_req    = 1'b1;
      OP_CFG_RS: d.restore_req = 1'b1;
      OP_CLAMP:  d.clamp       = 1'b1;
      OP_FLOAT:  d.highz       = 1'b1;
      default:   ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
  import cfg_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state,
  output logic       rti_enter
);

  tap_state_e nxt;
  logic       was_rti;

  always_comb begin
    case (state)
      TS_TLR:    nxt = tms ? TS_TLR    : TS_RTI;
      TS_RTI:    nxt = tms ? TS_SEL_DR : TS_RTI;
      TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
      TS_SHF_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
      TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SHF_DR;
      TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_RTI;
      TS_SEL_IR: nxt = tms ? TS_TLR    : TS_CAP_IR;
      TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
      TS_SHF_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
      TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SHF_IR;
      TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_RTI;
      default:   nxt = TS_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      state   <= TS_TLR;
      was_rti <= 1'b0;
    end else begin
      state   <= nxt;
      was_rti <= (state == TS_RTI);
    end
  end

  assign rti_enter = (state == TS_RTI) && !was_rti;

  // run-length of TMS-high edges, saturating at five
  logic [2:0] hi_run;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       hi_run <= 3'd0;
    else if (!tms)     hi_run <= 3'd0;
    else if (hi_run != 3'd5) hi_run <= hi_run + 3'd1;
  end

  AST_FIVE_HIGH_RESETS: assert property (@(posedge tck) disable iff (!trst_n)
    (hi_run == 3'd5) |-> (state == TS_TLR)); // R2

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
  import cfg_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_e state,
  input  logic       tdi,
  output ir_code_t   ir_q,
  output logic       ir_so
);

  ir_code_t ir_sh;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh <= IR_CAPTURE;
    end else if (state == TS_CAP_IR) begin
      ir_sh <= IR_CAPTURE;
    end else if (state == TS_SHF_IR) begin
      ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 ir_q <= OP_IDENT;
    else if (state == TS_TLR)    ir_q <= OP_IDENT;
    else if (state == TS_UPD_IR) ir_q <= ir_sh;
  end

  assign ir_so = ir_sh[0];

  AST_IR_HELD: assert property (@(posedge tck) disable iff (!trst_n)
    (state != TS_UPD_IR && state != TS_TLR) |=> $stable(ir_q)); // R3

  AST_IR_RESET_IDENT: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_TLR) |=> (ir_q == OP_IDENT)); // R2

endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
  import cfg_tap_pkg::*;
#(
  parameter logic [DR_W-1:0] ID_VALUE  = 32'h0000_0001,
  parameter logic [DR_W-1:0] CFG_RESET = 32'h0000_0000
) (
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  input  dr_path_e        path,
  input  logic            cap_id,
  input  logic            cap_bank,
  input  logic            wr_bank,
  input  logic            bsr_so,
  output logic            dr_so,
  output logic [DR_W-1:0] bank,
  output logic            bsr_capture,
  output logic            bsr_shift,
  output logic            bsr_update
);

  logic            byp_q;
  logic [DR_W-1:0] wide_sr;
  logic            in_cap, in_shf, in_upd;

  assign in_cap = (state == TS_CAP_DR);
  assign in_shf = (state == TS_SHF_DR);
  assign in_upd = (state == TS_UPD_DR);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
    end else if (path == PATH_BYP) begin
      if (in_cap)      byp_q <= 1'b0;
      else if (in_shf) byp_q <= tdi;
    end
  end

  // one register serves both the identification word and the bank path
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      wide_sr <= '0;
    end else if (path == PATH_WIDE) begin
      if (in_cap) begin
        if (cap_id)        wide_sr <= ID_VALUE;
        else if (cap_bank) wide_sr <= bank;
      end else if (in_shf) begin
        wide_sr <= {tdi, wide_sr[DR_W-1:1]};
      end
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)               bank <= CFG_RESET;
    else if (in_upd && wr_bank) bank <= wide_sr;
  end

  always_comb begin
    case (path)
      PATH_BSR:  dr_so = bsr_so;
      PATH_WIDE: dr_so = wide_sr[0];
      default:   dr_so = byp_q;
    endcase
  end

  assign bsr_capture = in_cap && (path == PATH_BSR);
  assign bsr_shift   = in_shf && (path == PATH_BSR);
  assign bsr_update  = in_upd && (path == PATH_BSR);

  AST_BYPASS_ZERO: assert property (@(posedge tck) disable iff (!trst_n)
    (in_cap && path == PATH_BYP) |=> (byp_q == 1'b0)); // R5

  AST_BANK_WRITE_ONLY: assert property (@(posedge tck) disable iff (!trst_n)
    !(in_upd && wr_bank) |=> $stable(bank)); // R7

  AST_BANK_READ_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
    (in_cap && path == PATH_WIDE && cap_bank) |=> (wide_sr == $past(bank))); // R8

endmodule

// File: rtl/cfg_tap_top.sv
`timescale 1ns/1ps
module cfg_tap_top
  import cfg_tap_pkg::*;
#(
  parameter logic [3:0]  ID_VERSION = 4'h0,
  parameter logic [15:0] ID_PART    = 16'h03A6,
  parameter logic [10:0] ID_MFR     = 11'h033,
  parameter logic [31:0] CFG_RESET  = 32'h0000_0000
) (
  input  logic        tck,
  input  logic        trst_n,
  input  logic        tms,
  input  logic        tdi,
  output logic        tdo,
  output logic        tdo_oe,
  input  logic        bsr_so,
  output logic        bsr_capture,
  output logic        bsr_shift,
  output logic        bsr_update,
  output logic        ext_test,
  output logic        clamp_en,
  output logic        highz_en,
  output logic [31:0] cfg_bank,
  output logic        save_strobe,
  output logic        restore_strobe
);

  localparam logic [DR_W-1:0] ID_VALUE = {ID_VERSION, ID_PART, ID_MFR, 1'b1};

  tap_state_e state;
  logic       rti_enter;
  ir_code_t   ir_q;
  logic       ir_so;
  ir_dec_t    dec;
  logic       dr_so;

  tap_fsm fsm_i (
    .tck       (tck),
    .trst_n    (trst_n),
    .tms       (tms),
    .state     (state),
    .rti_enter (rti_enter)
  );

  tap_ir ir_i (
    .tck    (tck),
    .trst_n (trst_n),
    .state  (state),
    .tdi    (tdi),
    .ir_q   (ir_q),
    .ir_so  (ir_so)
  );

  assign dec = decode_ir(ir_q);

  tap_dr #(
    .ID_VALUE  (ID_VALUE),
    .CFG_RESET (CFG_RESET)
  ) dr_i (
    .tck         (tck),
    .trst_n      (trst_n),
    .state       (state),
    .tdi         (tdi),
    .path        (dec.path),
    .cap_id      (dec.cap_id),
    .cap_bank    (dec.cap_bank),
    .wr_bank     (dec.wr_bank),
    .bsr_so      (bsr_so),
    .dr_so       (dr_so),
    .bank        (cfg_bank),
    .bsr_capture (bsr_capture),
    .bsr_shift   (bsr_shift),
    .bsr_update  (bsr_update)
  );

  logic in_shf_ir, in_shf_dr;
  assign in_shf_ir = (state == TS_SHF_IR);
  assign in_shf_dr = (state == TS_SHF_DR);

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= in_shf_ir || in_shf_dr;
      tdo    <= in_shf_ir ? ir_so : dr_so;
    end
  end

  assign save_strobe    = rti_enter && dec.save_req;
  assign restore_strobe = rti_enter && dec.restore_req;
  assign ext_test       = dec.ext;
  assign clamp_en       = dec.clamp;
  assign highz_en       = dec.highz;

  AST_OE_TRACKS_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == (in_shf_ir || in_shf_dr)); // R11

  AST_STROBE_ONE_CYCLE: assert property (@(posedge tck) disable iff (!trst_n)
    (save_strobe || restore_strobe) |=> !(save_strobe || restore_strobe)); // R9

  AST_MODE_EXCLUSIVE: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({ext_test, clamp_en, highz_en})); // R10

endmodule

// File: tb/cfg_tap_top_tb_top.sv
`timescale 1ns/1ps
module cfg_tap_top_tb_top;

  logic        tck = 1'b0;
  logic        trst_n = 1'b0;
  logic        tms = 1'b1;
  logic        tdi = 1'b0;
  logic        bsr_so = 1'b0;
  logic        tdo, tdo_oe, bsr_capture, bsr_shift, bsr_update;
  logic        ext_test, clamp_en, highz_en, save_strobe, restore_strobe;
  logic [31:0] cfg_bank;

  cfg_tap_top dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .bsr_so(bsr_so), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
    .bsr_update(bsr_update), .ext_test(ext_test), .clamp_en(clamp_en),
    .highz_en(highz_en), .cfg_bank(cfg_bank), .save_strobe(save_strobe),
    .restore_strobe(restore_strobe)
  );

  always #2 tck = ~tck;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [31:0] EXP_ID = {4'h0, 16'h03A6, 11'h033, 1'b1};

  // {code, clamp, highz, ext, bypass-path}
  localparam logic [7:0] VEC [16] = '{
    8'b0000_0010, 8'b0001_0000, 8'b0010_0000, 8'b0011_0001,
    8'b0100_0000, 8'b0101_0000, 8'b0110_0001, 8'b0111_0001,
    8'b1000_1001, 8'b1001_0101, 8'b1010_0001, 8'b1011_0001,
    8'b1100_0001, 8'b1101_0001, 8'b1110_0001, 8'b1111_0001
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive TMS/TDI after a falling edge, report TDO as seen there, return at the rising edge
  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck);
    #1;
    o   = tdo;
    tms = m;
    tdi = d;
    @(posedge tck);
  endtask

  task automatic mv(input logic m);
    logic o;
    step(m, 1'b0, o);
  endtask

  task automatic shift_ir(input logic [3:0] code, output logic [3:0] cap);
    logic o;
    mv(1); mv(1); mv(0); mv(0);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, code[i], o);
      cap[i] = o;
    end
    mv(1); mv(0);
  endtask

  task automatic shift_dr(input int n, input logic [31:0] din,
                          output logic [31:0] dout, output logic oe_all);
    logic o;
    dout   = '0;
    oe_all = 1'b1;
    mv(1); mv(0); mv(0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o);
      dout[i] = o;
      if (!tdo_oe) oe_all = 1'b0;
    end
    mv(1); mv(0);
  endtask

  task automatic do_reset();
    @(negedge tck);
    #1 trst_n = 1'b0;
    tms = 1'b1;
    repeat (2) @(posedge tck);
    @(negedge tck);
    #1 trst_n = 1'b1;
    mv(0);
  endtask

  logic [7:0]  v;
  logic [3:0]  cap;
  logic [31:0] d;
  logic        oe_ok, o1, o2;

  initial begin
    repeat (3) @(posedge tck);
    #1;
    chk("R1 bank in reset", cfg_bank, 32'h0);
    chk("R1 oe in reset", {31'b0, tdo_oe}, 32'h0);
    chk("R1 flags in reset",
        {27'b0, ext_test, clamp_en, highz_en, save_strobe, restore_strobe}, 32'h0);
    @(negedge tck);
    #1 trst_n = 1'b1;
    mv(0);
    #1 chk("R11 oe low in idle", {31'b0, tdo_oe}, 32'h0);

    shift_dr(32, 32'h0, d, oe_ok);
    chk("R6 identification word", d, EXP_ID);
    chk("R11 oe high while shifting", {31'b0, oe_ok}, 32'h1);

    // vector walk over all instruction codes
    bsr_so = 1'b1;
    for (int i = 0; i < 16; i++) begin
      v = VEC[i];
      shift_ir(v[7:4], cap);
      chk("R3 capture pattern", {28'b0, cap}, 32'h1);
      #1 chk($sformatf("R10 flags code %h", v[7:4]),
             {29'b0, clamp_en, highz_en, ext_test}, {29'b0, v[3:1]});
      shift_dr(2, 32'h3, d, oe_ok);
      if (v[0]) chk($sformatf("R4 R5 bypass code %h", v[7:4]), {30'b0, d[1:0]}, 32'h2);
    end
    bsr_so = 1'b0;

    // bank write and read-back
    do_reset();
    shift_ir(4'b0100, cap);
    shift_dr(32, 32'hA5C3_1E69, d, oe_ok);
    #1 chk("R7 bank written", cfg_bank, 32'hA5C3_1E69);
    shift_ir(4'b0101, cap);
    shift_dr(32, 32'h0, d, oe_ok);
    chk("R8 bank read", d, 32'hA5C3_1E69);
    #1 chk("R7 bank kept under read", cfg_bank, 32'hA5C3_1E69);
    shift_ir(4'b1111, cap);
    shift_dr(32, 32'h1234_5678, d, oe_ok);
    #1 chk("R7 bank kept under bypass", cfg_bank, 32'hA5C3_1E69);

    // TDO holds across the rising edge (bank bit0=1, bit1=0)
    shift_ir(4'b0101, cap);
    mv(1); mv(0); mv(0);
    step(0, 0, o1);
    #1 chk("R11 tdo stable at rising edge", {31'b0, tdo}, {31'b0, o1});
    step(1, 0, o2);
    chk("R11 tdo after falling edge", {30'b0, o1, o2}, 32'h2);
    mv(1); mv(0);

    // save / restore strobes
    shift_ir(4'b0110, cap);
    #1 chk("R9 save strobe", {30'b0, save_strobe, restore_strobe}, 32'h2);
    mv(0);
    #1 chk("R9 save strobe single", {30'b0, save_strobe, restore_strobe}, 32'h0);
    shift_ir(4'b0111, cap);
    #1 chk("R9 restore strobe", {30'b0, save_strobe, restore_strobe}, 32'h1);
    mv(0);
    #1 chk("R9 restore strobe single", {30'b0, save_strobe, restore_strobe}, 32'h0);

    // pending instruction held in Pause-IR
    shift_ir(4'b1111, cap);
    mv(1); mv(1); mv(0); mv(0);
    step(0, 0, o1); step(0, 0, o1); step(0, 0, o1); step(1, 1, o1);
    mv(0);
    #1 chk("R3 clamp pending in pause", {31'b0, clamp_en}, 32'h0);
    mv(1); mv(1); mv(0);
    #1 chk("R3 clamp after update", {31'b0, clamp_en}, 32'h1);

    // boundary handshake
    shift_ir(4'b0000, cap);
    bsr_so = 1'b1;
    mv(1); mv(0);
    #1 chk("R12 capture enable", {29'b0, bsr_capture, bsr_shift, bsr_update}, 32'h4);
    mv(0);
    #1 chk("R12 shift enable", {29'b0, bsr_capture, bsr_shift, bsr_update}, 32'h2);
    step(1, 0, o1);
    chk("R12 tdo carries chain", {31'b0, o1}, 32'h1);
    mv(1);
    #1 chk("R12 update enable", {29'b0, bsr_capture, bsr_shift, bsr_update}, 32'h1);
    mv(0);
    bsr_so = 1'b0;

    // five TMS-high edges from Shift-DR
    shift_ir(4'b1111, cap);
    mv(1); mv(0); mv(0);
    mv(1); mv(1); mv(1); mv(1); mv(1);
    mv(0);
    shift_dr(32, 32'h0, d, oe_ok);
    chk("R2 instruction back to identification", d, EXP_ID);

    // asynchronous reset clears the bank
    shift_ir(4'b0100, cap);
    shift_dr(32, 32'h0F0F_00FF, d, oe_ok);
    do_reset();
    #1 chk("R1 bank cleared by trst", cfg_bank, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule